// File: doc/BRIEF.md
# Two-bit event state buffer for message and level interrupt sources

This block keeps a two-bit state for each of a parameterised number of interrupt sources. One bit records that the source has been presented to the interrupt routing logic (P). The other bit records that a further event arrived while the first was still outstanding, or that the source is masked (Q). Software and devices reach the block through a plain address/read/write port. The address and the access direction choose the operation, and any write data plays no part. Loads have side effects: each one returns the state the source held before the access.

Each source owns a management page and a trigger page. A store anywhere in a source's trigger page fires that source. Loads at fixed slots of the management page unmask the source, mask it, or retire it (end of interrupt). A store at a separate management slot also retires it. When a trigger finds the source idle, or a retire finds a second event waiting, the block emits a one-cycle notify pulse for that source. The routing logic downstream then queues the event. Sources chosen as level-sensitive by parameter have no usable trigger page. Their input line acts as the trigger instead, which makes a line that stays high re-present the source each time it is retired.

Top module: `esb_pq_unit`

## Requirements
- R1: After reset every source holds PQ=01 (masked), `notify_o` is all zero and `rvalid_o` is low.
- R2: `addr_i` is laid out as {page select, source index, slot[3:0], 8 ignored low bits}. Page select 1 is the trigger page and 0 is the management page. A source index of NUM_SRC or more changes no state, and a load to it returns 00.
- R3: A load sets `rvalid_o` one cycle later, with `rdata_o` holding the pre-access state (bit 1 = P, bit 0 = Q). A management load at slot 0xC sets PQ to 00 (unmask). A management load at slot 0xD sets PQ to 01 (mask).
- R4: A store to the trigger page of an edge source moves PQ 00→10 and pulses the notify bit, 10→11, and 11→11. A store in state 01 leaves PQ at 01 with no pulse.
- R5: End of interrupt is a management store at slot 0x4 or a management load at slot 0x0. It moves PQ 10→00, and 11→10 with a notify pulse. It leaves 00 and 01 unchanged.
- R6: Management loads at any other slot and trigger-page loads return PQ unchanged. Management stores at any slot other than 0x4 are ignored.
- R7: For a level source, trigger-page stores are ignored, and a high `lvl_i` bit acts as a trigger in every cycle. This trigger is applied after any bus operation to the same source in that cycle. Edge sources ignore `lvl_i`.
- R8: An unmask load that returns Q=1 reports that a trigger may have been dropped while masked, and the source is left at 00. A store trigger after that unmask presents the source again with a notify pulse.
- R9: `notify_o` has one registered bit per source, high for exactly one cycle in the cycle after the causing event. Several sources may pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | AW | {page select, source index, slot, low bits} |
| lvl_i | input | NUM_SRC | Interrupt lines, used only by level sources |
| rvalid_o | output | 1 | Load result valid, one cycle after the load |
| rdata_o | output | 2 | Pre-access PQ of the loaded source |
| notify_o | output | NUM_SRC | Per-source presentation pulse |

## Verification
The bench builds the block with NUM_SRC=6, sources 4 and 5 level-sensitive, and an 8-bit low-address field. With six sources the 3-bit index field can address sources 6 and 7, which do not exist, so out-of-range accesses can be exercised. Having both source kinds present lets the same bench show trigger stores being ignored on level sources while line triggers combine with unmask and retire operations in the same cycle. With two level lines high at once, two notify bits pulse together in one cycle.

// File: rtl/esb_pkg.sv
package esb_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_CLR,
    OP_MASK
  } esb_op_e;

  localparam logic [1:0] PQ_RESET = 2'b01;

  // returns {notify, next_pq}
  function automatic logic [2:0] pq_trigger(input logic [1:0] pq);
    case (pq)
      2'b00:   return 3'b1_10;
      2'b10:   return 3'b0_11;
      default: return {1'b0, pq};
    endcase
  endfunction

  function automatic logic [2:0] pq_retire(input logic [1:0] pq);
    case (pq)
      2'b10:   return 3'b0_00;
      2'b11:   return 3'b1_10;
      default: return {1'b0, pq};
    endcase
  endfunction

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
  import esb_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int LOW_BITS = 8,
  localparam int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int AW      = 1 + IW + 4 + LOW_BITS
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  output esb_op_e            op_o,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               hit_o,
  output logic               load_o
);
  localparam logic [3:0] SLOT_LD_EOI = 4'h0;
  localparam logic [3:0] SLOT_ST_EOI = 4'h4;
  localparam logic [3:0] SLOT_UNMASK = 4'hC;
  localparam logic [3:0] SLOT_MASK   = 4'hD;

  logic          trig_page;
  logic [IW-1:0] idx;
  logic [3:0]    slot;
  logic          unused_low;

  assign trig_page  = addr_i[AW-1];
  assign idx        = addr_i[LOW_BITS+4 +: IW];
  assign slot       = addr_i[LOW_BITS +: 4];
  assign unused_low = ^addr_i[LOW_BITS-1:0];

  assign hit_o  = req_i && (int'(idx) < NUM_SRC);
  assign load_o = req_i && !we_i;

  always_comb begin
    op_o = OP_NONE;
    if (hit_o) begin
      if (trig_page) begin
        if (we_i) op_o = OP_TRIG;
      end else if (we_i) begin
        if (slot == SLOT_ST_EOI) op_o = OP_EOI;
      end else begin
        case (slot)
          SLOT_LD_EOI: op_o = OP_EOI;
          SLOT_UNMASK: op_o = OP_CLR;
          SLOT_MASK:   op_o = OP_MASK;
          default:     op_o = OP_NONE;
        endcase
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    assign sel_o[s] = hit_o && (idx == IW'(s));
  end

endmodule

// File: rtl/esb_cell.sv
module esb_cell
  import esb_pkg::*;
#(
  parameter bit IS_LVL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  esb_op_e    op_i,
  input  logic       lvl_i,
  output logic [1:0] pq_o,
  output logic       notify_o
);
  logic [1:0] pq_q, pq_bus, pq_d;
  logic       nt_bus, nt_d, notify_q;
  logic [2:0] step_bus, step_lvl;
  logic       lvl_trig;

  assign lvl_trig = IS_LVL && lvl_i;

  always_comb begin
    step_bus = {1'b0, pq_q};
    case (op_i)
      OP_TRIG: if (!IS_LVL) step_bus = pq_trigger(pq_q);
      OP_EOI:  step_bus = pq_retire(pq_q);
      OP_CLR:  step_bus = 3'b0_00;
      OP_MASK: step_bus = 3'b0_01;
      default: step_bus = {1'b0, pq_q};
    endcase
    {nt_bus, pq_bus} = step_bus;
    // line trigger lands after the bus operation
    step_lvl = lvl_trig ? pq_trigger(pq_bus) : {1'b0, pq_bus};
    pq_d = step_lvl[1:0];
    nt_d = nt_bus | step_lvl[2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q     <= PQ_RESET;
      notify_q <= 1'b0;
    end else begin
      pq_q     <= pq_d;
      notify_q <= nt_d;
    end
  end

  assign pq_o     = pq_q;
  assign notify_o = notify_q;

  assert_notify_presents_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_q |-> pq_q[1]);

  assert_mask_sets_01_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_MASK |=> pq_q == 2'b01);

  assert_masked_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == 2'b01 && op_i != OP_CLR) |=> !notify_q);

  assert_eoi_retires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_EOI && pq_q == 2'b10 && !lvl_trig) |=> pq_q == 2'b00);

  assert_lvl_ignores_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_LVL && op_i == OP_TRIG && !lvl_i) |=> $stable(pq_q));

endmodule

// File: rtl/esb_pq_unit.sv
module esb_pq_unit
  import esb_pkg::*;
#(
  parameter int                 NUM_SRC  = 32,
  parameter int                 LOW_BITS = 8,
  parameter logic [NUM_SRC-1:0] LVL_SRC  = '0,
  localparam int                IW       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int                AW       = 1 + IW + 4 + LOW_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic               rvalid_o,
  output logic [1:0]         rdata_o,
  output logic [NUM_SRC-1:0] notify_o
);
  esb_op_e            op;
  logic [NUM_SRC-1:0] sel;
  logic               hit, load;
  logic [1:0]         pq_w [NUM_SRC];
  logic [1:0]         rdata_d;
  logic               rvalid_q;
  logic [1:0]         rdata_q;

  esb_addr_decode #(
    .NUM_SRC (NUM_SRC),
    .LOW_BITS(LOW_BITS)
  ) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .op_o  (op),
    .sel_o (sel),
    .hit_o (hit),
    .load_o(load)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    esb_op_e op_s;
    assign op_s = sel[s] ? op : OP_NONE;

    esb_cell #(
      .IS_LVL(LVL_SRC[s])
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op_s),
      .lvl_i   (lvl_i[s]),
      .pq_o    (pq_w[s]),
      .notify_o(notify_o[s])
    );
  end

  always_comb begin
    rdata_d = 2'b00;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (sel[s]) rdata_d = rdata_d | pq_w[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 2'b00;
    end else begin
      rvalid_q <= load;
      rdata_q  <= (load && hit) ? rdata_d : 2'b00;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  assert_load_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_store_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  assert_miss_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !hit) |=> rdata_o == 2'b00);

endmodule

// File: tb/sim_esb_pq_unit.sv
module sim_esb_pq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 6;
  localparam int LB = 8;
  localparam int AW = 1 + 3 + 4 + LB;
  localparam logic [N-1:0] LVL = 6'b110000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  lvl = '0;
  logic          rvalid;
  logic [1:0]    rdata;
  logic [N-1:0]  notify;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int pq [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_pq_unit #(.NUM_SRC(N), .LOW_BITS(LB), .LVL_SRC(LVL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .lvl_i(lvl), .rvalid_o(rvalid), .rdata_o(rdata), .notify_o(notify)
  );

  function automatic void m_trig(inout int v, inout bit f);
    if (v == 0) begin v = 2; f = 1; end
    else if (v == 2) v = 3;
  endfunction

  function automatic void m_eoi(inout int v, inout bit f);
    if (v == 2) v = 0;
    else if (v == 3) begin v = 2; f = 1; end
  endfunction

  // one clock: drive, advance the model, compare after the edge
  task automatic step(bit rq, bit w, int src, bit tp, int slot, int low,
                      logic [N-1:0] lv, string tag);
    bit          exp_rv;
    logic [1:0]  exp_rd;
    logic [N-1:0] exp_nt;
    @(negedge clk);
    req  = rq;
    we   = w;
    addr = {tp, 3'(src), 4'(slot), 8'(low)};
    lvl  = lv;
    exp_rv = rq && !w;
    exp_rd = 2'b00;
    exp_nt = '0;
    for (int s = 0; s < N; s++) begin
      int v = pq[s];
      bit f = 0;
      if (rq && s == src) begin
        if (!w) exp_rd = 2'(v);
        if (tp) begin
          if (w && !LVL[s]) m_trig(v, f);
        end else if (w) begin
          if (slot == 4) m_eoi(v, f);
        end else begin
          if (slot == 0) m_eoi(v, f);
          else if (slot == 12) v = 0;
          else if (slot == 13) v = 1;
        end
      end
      if (LVL[s] && lv[s]) m_trig(v, f);
      pq[s] = v;
      exp_nt[s] = f;
    end
    @(posedge clk);
    #1;
    tests++;
    if (rvalid !== exp_rv || (exp_rv && rdata !== exp_rd) || notify !== exp_nt) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%0b notify=%b, expected rvalid=%0b rdata=%0b notify=%b",
               tag, rvalid, rdata, notify, exp_rv, exp_rd, exp_nt);
    end
  endtask

  task automatic query(int src, string tag);
    step(1, 0, src, 0, 2, 0, '0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) pq[s] = 1;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle outputs and masked state everywhere
    step(0, 0, 0, 0, 0, 0, '0, "R1 idle after reset");
    for (int s = 0; s < N; s++) query(s, "R1 reset PQ=01");
    // R3: unmask returns old state
    step(1, 0, 0, 0, 12, 0, '0, "R3 unmask src0");
    // R4: trigger ladder
    step(1, 1, 0, 1, 0, 0, '0, "R4 trigger 00->10 notify");
    query(0, "R4 state 10");
    step(1, 1, 0, 1, 7, 3, '0, "R4 trigger 10->11");
    step(1, 1, 0, 1, 0, 0, '0, "R4 trigger 11 stays");
    query(0, "R4 state 11");
    // R5: both retire forms
    step(1, 1, 0, 0, 4, 0, '0, "R5 store retire 11->10 notify");
    step(1, 0, 0, 0, 0, 0, '0, "R5 load retire 10->00");
    step(1, 0, 0, 0, 0, 0, '0, "R5 load retire at 00 unchanged");
    step(1, 1, 0, 0, 4, 0, '0, "R5 store retire at 00 unchanged");
    // R3/R4/R8: mask, dropped trigger, unmask, re-trigger
    step(1, 0, 0, 0, 13, 0, '0, "R3 mask src0");
    step(1, 1, 0, 1, 0, 0, '0, "R4 trigger while masked silent");
    step(1, 0, 0, 0, 4, 0, '0, "R5 load at slot4 no retire");
    step(1, 0, 0, 0, 12, 8'hFF, '0, "R8 unmask reports Q");
    step(1, 1, 0, 1, 0, 0, '0, "R8 re-trigger presents");
    // R6: ignored stores, side-effect-free loads
    step(1, 1, 0, 0, 12, 0, '0, "R6 store at unmask slot ignored");
    step(1, 1, 0, 0, 0, 0, '0, "R6 store at slot0 ignored");
    step(1, 0, 0, 1, 0, 0, '0, "R6 trigger page load");
    query(0, "R6 state kept 10");
    // R7: level sources
    step(1, 1, 4, 1, 0, 0, '0, "R7 store trigger on level ignored");
    query(4, "R7 level still 01");
    step(1, 0, 4, 0, 12, 0, '0, "R3 unmask src4");
    step(0, 0, 0, 0, 0, 0, 6'b010000, "R7 line raises 00->10");
    step(0, 0, 0, 0, 0, 0, 6'b010000, "R7 line held 10->11");
    step(1, 1, 4, 0, 4, 0, '0, "R7 retire 11->10 notify");
    step(1, 1, 4, 0, 4, 0, 6'b010000, "R7 retire then line 00->10");
    step(1, 0, 4, 0, 0, 0, '0, "R7 load retire src4");
    step(1, 0, 5, 0, 12, 0, 6'b100000, "R7 unmask with line same cycle");
    step(1, 0, 5, 0, 13, 0, 6'b100000, "R7 mask beats line");
    step(0, 0, 0, 0, 0, 0, 6'b001111, "R7 edge sources ignore lines");
    query(1, "R7 src1 untouched");
    // R9: two sources pulse together
    step(1, 0, 5, 0, 12, 0, '0, "R9 unmask src5");
    step(0, 0, 0, 0, 0, 0, 6'b110000, "R9 dual notify");
    step(0, 0, 0, 0, 0, 0, 6'b000000, "R9 pulse one cycle");
    // R2: out-of-range indices
    step(1, 0, 6, 0, 12, 0, '0, "R2 load src6 returns 00");
    step(1, 1, 7, 1, 0, 0, '0, "R2 trigger src7 no effect");
    step(1, 0, 7, 0, 13, 0, '0, "R2 load src7 returns 00");
    for (int s = 0; s < N; s++) query(s, "R2 states intact");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule